// File: doc/BRIEF.md
# Watchdog Timer with Write-Locked Timeout

This block is a host-serviced watchdog. A reference-clock enable pulse arrives from the system clock domain. The block divides it down to a slow counter tick. The counter counts down from a programmed 6-bit timeout value. If the host does not service the watchdog before the count reaches zero, a sticky timeout flag is set. If interrupts are enabled, an interrupt request is also raised. The host clears both by reading the flags register, signalled here by a one-cycle `flag_rd` pulse.

The host talks to the block through one 8-bit write port:

- Bits 5:0 carry the timeout value.
- Bit 6 is a per-write lock. When it is 1, bits 5:0 are ignored.
- Bit 7 is the service strobe.

With the lock, the host can service the watchdog without disturbing the programmed timeout. A timeout value of zero turns the watchdog off.

The counter is a three-state machine:

- OFF: idle, count 0.
- RUN: counting down.
- EXPIRED: holding at zero.

Its transitions are:

- LOAD_ZERO: any state to OFF, when a reload carries value 0.
- LOAD_NZ: any state to RUN, when a reload carries a nonzero value.
- EXPIRE: RUN to EXPIRED, when a tick arrives at count 1.
- STAY: no reload and no expiry.

A reload outranks a tick in the same cycle. A reload also restarts the prescaler.

Top module: `wdt_guard`

## Requirements
- R1: After reset, `count`, `timeout_val`, `wdf` and `irq` are all 0, and the watchdog is off.
- R2: After a reload, `count` drops by one on every PRESC-th cycle with `ref_tick` high, counted from the reload. PRESC defaults to 1024, which gives 32 Hz from a 32.768 kHz enable. Cycles with `ref_tick` low advance nothing.
- R3: A write with bit 6 = 0 stores bits 5:0 into `timeout_val` and restarts the count from that value, even mid-count.
- R4: A write with bit 6 = 1 leaves `timeout_val` unchanged. If bit 7 of that write is 0, the count is also unchanged.
- R5: A write with bit 7 = 1 reloads the count with the programmed timeout value. Servicing before zero never sets `wdf`.
- R6: With a timeout value of 0, the count stays 0 and `wdf` never sets, even when a service strobe is written.
- R7: When the count reaches zero, `wdf` sets. The count then holds at 0. `wdf` sets only once per expiry, so after a clear it stays 0 while the count holds.
- R8: `irq` is raised at expiry only when `irq_en` is 1 in that cycle.
- R9: A `flag_rd` pulse clears both `wdf` and `irq` on the next clock.
- R10: When `flag_rd` and an expiry fall in the same cycle, `wdf` (and `irq` if enabled) end up set.
- R11: A service strobe in the same cycle as the final tick wins: no expiry occurs, and the count reloads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle enable at the reference clock rate |
| wr_en | input | 1 | Write strobe for the control register |
| wr_data | input | 8 | Bit 7 service, bit 6 lock, bits 5:0 timeout |
| irq_en | input | 1 | Watchdog interrupt enable |
| flag_rd | input | 1 | Host read of the flags register (clears the flag) |
| timeout_val | output | 6 | Programmed timeout value |
| count | output | 6 | Current countdown value |
| wdf | output | 1 | Sticky timeout flag |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of functions can land in the same cycle:

- A host flags read and the expiry of the counter.
- A service strobe and the last counter tick.

The bench asks its behavioural model whether the next cycle's inputs would cause an expiry. It then places the read, or the service write, in exactly that cycle. For the first pair, the flag and the interrupt must remain set. For the second, no flag may appear and the count must come back at the full timeout. Every output is compared against the model on every clock.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;

    typedef enum logic [1:0] {
        ST_OFF     = 2'd0,
        ST_RUN     = 2'd1,
        ST_EXPIRED = 2'd2
    } wdt_state_e;

endpackage

// File: rtl/wdt_presc.sv
module wdt_presc #(
    parameter int DIV = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_tick,
    input  logic restart,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] pre_q;
    logic          at_last;

    assign at_last = (pre_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (restart) begin
            pre_q <= '0;
        end else if (ref_tick) begin
            pre_q <= at_last ? '0 : pre_q + 1'b1;
        end
    end

    assign tick = ref_tick && at_last;

    // R2: a slow tick only occurs on a reference enable
    p_tick_needs_ref_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> ref_tick);

    // R2: divider never leaves its range
    p_pre_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q <= LAST);

    // R2: divider holds when no enable and no restart
    p_pre_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ref_tick && !restart) |=> $stable(pre_q));

endmodule

// File: rtl/wdt_loadreg.sv
module wdt_loadreg #(
    parameter int TMO_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_lock,
    input  logic             wr_svc,
    input  logic [TMO_W-1:0] wr_val,
    output logic [TMO_W-1:0] tmo_q,
    output logic             load,
    output logic [TMO_W-1:0] load_val
);
    logic upd;

    assign upd      = wr_en && !wr_lock;
    assign load     = wr_en && (wr_svc || !wr_lock);
    assign load_val = upd ? wr_val : tmo_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmo_q <= '0;
        end else if (upd) begin
            tmo_q <= wr_val;
        end
    end

    // R4: a locked write never alters the stored timeout
    p_lock_keeps_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_lock) |=> $stable(tmo_q));

    // R3: an unlocked write stores its value
    p_unlocked_stores_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_lock) |=> (tmo_q == $past(wr_val)));

    // R4: with no write the timeout is kept
    p_no_write_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(tmo_q));

endmodule

// File: rtl/wdt_cnt_fsm.sv
module wdt_cnt_fsm
    import wdt_guard_pkg::*;
#(
    parameter int TMO_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [TMO_W-1:0] load_val,
    output logic [TMO_W-1:0] cnt_q,
    output logic             expire
);
    localparam logic [TMO_W-1:0] ONE = TMO_W'(1);

    wdt_state_e       state_q, state_n;
    logic [TMO_W-1:0] cnt_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end

    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        if (load) begin
            cnt_n   = load_val;
            state_n = (load_val != '0) ? ST_RUN : ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    cnt_n = '0;
                end
                ST_RUN: begin
                    if (tick) begin
                        if (cnt_q == ONE) begin
                            cnt_n   = '0;
                            state_n = ST_EXPIRED;
                        end else begin
                            cnt_n = cnt_q - ONE;
                        end
                    end
                end
                ST_EXPIRED: begin
                    cnt_n = '0;
                end
                default: begin
                    cnt_n   = '0;
                    state_n = ST_OFF;
                end
            endcase
        end
    end

    always_comb begin
        expire = 1'b0;
        unique case (state_q)
            ST_RUN:     expire = tick && !load && (cnt_q == ONE);
            ST_OFF:     expire = 1'b0;
            ST_EXPIRED: expire = 1'b0;
            default:    expire = 1'b0;
        endcase
    end

    // R7: a running counter is never at zero
    p_run_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> (cnt_q != '0));

    // R7: expired counter holds at zero until reloaded
    p_hold_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXPIRED && !load) |=> (state_q == ST_EXPIRED && cnt_q == '0));

    // R7: one expiry per countdown
    p_expire_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !expire);

    // R6: disabled watchdog keeps count at zero
    p_off_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF) |-> (cnt_q == '0));

    // R11: a nonzero reload always restarts the countdown, even on a final tick
    p_reload_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_val != '0) |=> (state_q == ST_RUN && cnt_q == $past(load_val)));

endmodule

// File: rtl/wdt_flag.sv
module wdt_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic irq_en,
    input  logic flag_rd,
    output logic flag_q,
    output logic irq_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            if (expire)       flag_q <= 1'b1;
            else if (flag_rd) flag_q <= 1'b0;

            if (expire && irq_en) irq_q <= 1'b1;
            else if (flag_rd)     irq_q <= 1'b0;
        end
    end

    // R10: an expiry sets the flag even under a simultaneous read
    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> flag_q);

    // R9: a read with no expiry clears flag and request
    p_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_rd && !expire) |=> (!flag_q && !irq_q));

    // R8: the request never stands without the flag
    p_irq_has_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> flag_q);

    // R8: a masked expiry raises no request
    p_irq_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_q && !(expire && irq_en)) |=> !irq_q);

endmodule

// File: rtl/wdt_guard.sv
module wdt_guard #(
    parameter int TMO_W = 6,
    parameter int PRESC = 1024
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ref_tick,
    input  logic               wr_en,
    input  logic [TMO_W+1:0]   wr_data,
    input  logic               irq_en,
    input  logic               flag_rd,
    output logic [TMO_W-1:0]   timeout_val,
    output logic [TMO_W-1:0]   count,
    output logic               wdf,
    output logic               irq
);
    localparam int LOCK_POS = TMO_W;
    localparam int SVC_POS  = TMO_W + 1;

    logic             tick;
    logic             load;
    logic             expire;
    logic [TMO_W-1:0] load_val;

    wdt_presc #(.DIV(PRESC)) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_tick (ref_tick),
        .restart  (load),
        .tick     (tick)
    );

    wdt_loadreg #(.TMO_W(TMO_W)) u_loadreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_lock  (wr_data[LOCK_POS]),
        .wr_svc   (wr_data[SVC_POS]),
        .wr_val   (wr_data[TMO_W-1:0]),
        .tmo_q    (timeout_val),
        .load     (load),
        .load_val (load_val)
    );

    wdt_cnt_fsm #(.TMO_W(TMO_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load     (load),
        .load_val (load_val),
        .cnt_q    (count),
        .expire   (expire)
    );

    wdt_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .expire  (expire),
        .irq_en  (irq_en),
        .flag_rd (flag_rd),
        .flag_q  (wdf),
        .irq_q   (irq)
    );

    // R5: a service write with nonzero timeout cannot produce a flag next cycle
    p_service_no_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[SVC_POS] && !wdf && timeout_val != '0) |=> !wdf);

endmodule

// File: tb/wdt_guard_bench.sv
module wdt_guard_bench;
    localparam int CLK_PERIOD = 10;
    localparam int PRESC      = 4;
    localparam int WD_LIMIT   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       irq_en = 1'b0;
    logic       flag_rd = 1'b0;
    logic [5:0] timeout_val;
    logic [5:0] count;
    logic       wdf;
    logic       irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdt_guard #(.TMO_W(6), .PRESC(PRESC)) u_wdt_guard (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .wr_en(wr_en),
        .wr_data(wr_data), .irq_en(irq_en), .flag_rd(flag_rd),
        .timeout_val(timeout_val), .count(count), .wdf(wdf), .irq(irq)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 0;
    string cur_tag  = "R1";
    logic  ien_g    = 1'b0;

    // behavioural reference model
    int m_pre = 0, m_cnt = 0, m_tmo = 0;
    bit m_run = 0, m_flag = 0, m_irq = 0;

    task automatic check_eq(input int act, input int exp, input string tag, input string what);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check_eq(int'(count), m_cnt, cur_tag, "count");
        check_eq(int'(timeout_val), m_tmo, cur_tag, "timeout_val");
        check_eq(int'(wdf), int'(m_flag), cur_tag, "wdf");
        check_eq(int'(irq), int'(m_irq), cur_tag, "irq");
    endtask

    function automatic bit would_expire(input bit r, input bit w, input logic [7:0] d);
        bit ld;
        ld = w && (d[7] || !d[6]);
        return !ld && m_run && r && (m_pre == PRESC-1) && (m_cnt == 1);
    endfunction

    task automatic model_advance(input bit r, input bit w, input logic [7:0] d, input bit ie, input bit rd);
        bit ld, tk, ex;
        int lv;
        ld = w && (d[7] || !d[6]);
        tk = r && (m_pre == PRESC-1);
        lv = (w && !d[6]) ? int'(d[5:0]) : m_tmo;
        ex = 0;
        if (w && !d[6]) m_tmo = int'(d[5:0]);
        if (ld) begin
            m_cnt = lv;
            m_run = (lv != 0);
        end else if (m_run && tk) begin
            if (m_cnt == 1) begin
                m_cnt = 0;
                m_run = 0;
                ex = 1;
            end else begin
                m_cnt = m_cnt - 1;
            end
        end
        if (ld) m_pre = 0;
        else if (r) m_pre = (m_pre == PRESC-1) ? 0 : m_pre + 1;
        if (ex) m_flag = 1; else if (rd) m_flag = 0;
        if (ex && ie) m_irq = 1; else if (rd) m_irq = 0;
    endtask

    task automatic step(input bit r, input bit w, input logic [7:0] d, input bit rd);
        @(negedge clk);
        compare_all();
        ref_tick = r; wr_en = w; wr_data = d; irq_en = ien_g; flag_rd = rd;
        model_advance(r, w, d, ien_g, rd);
    endtask

    task automatic refs(input int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, 8'h00, 1'b0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 8'h00, 1'b0);
    endtask

    // one idle step so that outputs reflect every earlier stimulus
    task automatic settle();
        step(1'b0, 1'b0, 8'h00, 1'b0);
    endtask

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        cur_tag = "R1";
        check_eq(int'(count), 0, "R1", "count in reset");
        check_eq(int'(timeout_val), 0, "R1", "timeout in reset");
        check_eq(int'(wdf), 0, "R1", "wdf in reset");
        check_eq(int'(irq), 0, "R1", "irq in reset");
        rst_n = 1'b1;
        refs(10);
        settle();
        check_eq(int'(count), 0, "R1", "count stays off after reset");

        // R3: unlocked write programs and starts
        cur_tag = "R3";
        step(1'b0, 1'b1, 8'h03, 1'b0);
        settle();
        check_eq(int'(timeout_val), 3, "R3", "timeout programmed");
        check_eq(int'(count), 3, "R3", "count loaded");

        // R2: decrement every PRESC enables, none without enable
        cur_tag = "R2";
        refs(PRESC);
        settle();
        check_eq(int'(count), 2, "R2", "count after PRESC enables");
        idle(10);
        settle();
        check_eq(int'(count), 2, "R2", "count without enables");
        refs(PRESC-1);
        settle();
        check_eq(int'(count), 2, "R2", "count one enable short");
        refs(1);
        settle();
        check_eq(int'(count), 1, "R2", "count after next tick");

        // R7 / R8: expiry with interrupt disabled
        cur_tag = "R7";
        refs(PRESC);
        settle();
        check_eq(int'(count), 0, "R7", "count at expiry");
        check_eq(int'(wdf), 1, "R7", "flag at expiry");
        check_eq(int'(irq), 0, "R8", "irq masked");
        refs(3*PRESC);
        settle();
        check_eq(int'(count), 0, "R7", "count holds at zero");

        // R9: read clears
        cur_tag = "R9";
        step(1'b0, 1'b0, 8'h00, 1'b1);
        settle();
        check_eq(int'(wdf), 0, "R9", "flag cleared by read");
        cur_tag = "R7";
        refs(3*PRESC);
        settle();
        check_eq(int'(wdf), 0, "R7", "no second flag while holding");

        // R4: locked write ignores value
        cur_tag = "R4";
        step(1'b0, 1'b1, 8'h45, 1'b0);
        settle();
        check_eq(int'(timeout_val), 3, "R4", "locked value ignored");
        check_eq(int'(count), 0, "R4", "locked write no reload");
        step(1'b0, 1'b1, 8'hC5, 1'b0);
        settle();
        check_eq(int'(timeout_val), 3, "R4", "locked service keeps value");
        check_eq(int'(count), 3, "R5", "locked service reloads");

        // R5: periodic servicing prevents timeout
        cur_tag = "R5";
        for (int k = 0; k < 10; k++) begin
            refs(3*PRESC - 1);
            step(1'b1, 1'b1, 8'hC0, 1'b0);
        end
        settle();
        check_eq(int'(wdf), 0, "R5", "no flag with servicing");
        check_eq(int'(count), 3, "R5", "count reloaded");

        // R8: expiry with interrupt enabled
        cur_tag = "R8";
        ien_g = 1'b1;
        refs(3*PRESC);
        settle();
        check_eq(int'(wdf), 1, "R8", "flag set");
        check_eq(int'(irq), 1, "R8", "irq raised");
        cur_tag = "R9";
        step(1'b0, 1'b0, 8'h00, 1'b1);
        settle();
        check_eq(int'(wdf), 0, "R9", "flag cleared");
        check_eq(int'(irq), 0, "R9", "irq cleared");

        // R10: read in the expiry cycle
        cur_tag = "R10";
        step(1'b0, 1'b1, 8'hC0, 1'b0);
        for (int k = 0; k < 40; k++) begin
            if (would_expire(1'b1, 1'b0, 8'h00)) begin
                step(1'b1, 1'b0, 8'h00, 1'b1);
                break;
            end
            step(1'b1, 1'b0, 8'h00, 1'b0);
        end
        settle();
        check_eq(int'(wdf), 1, "R10", "set wins over read");
        check_eq(int'(irq), 1, "R10", "irq set wins over read");
        step(1'b0, 1'b0, 8'h00, 1'b1);
        settle();

        // R11: service on the final tick
        cur_tag = "R11";
        step(1'b0, 1'b1, 8'hC0, 1'b0);
        for (int k = 0; k < 40; k++) begin
            if (would_expire(1'b1, 1'b0, 8'h00)) begin
                step(1'b1, 1'b1, 8'hC0, 1'b0);
                break;
            end
            step(1'b1, 1'b0, 8'h00, 1'b0);
        end
        settle();
        check_eq(int'(wdf), 0, "R11", "service wins over final tick");
        check_eq(int'(count), 3, "R11", "count reloaded on final tick");

        // R3: reprogram mid-count
        cur_tag = "R3";
        refs(PRESC + 1);
        step(1'b0, 1'b1, 8'h05, 1'b0);
        settle();
        check_eq(int'(count), 5, "R3", "restart from new value");
        check_eq(int'(timeout_val), 5, "R3", "new value stored");

        // R6: zero disables
        cur_tag = "R6";
        step(1'b0, 1'b1, 8'h00, 1'b0);
        settle();
        check_eq(int'(count), 0, "R6", "count off");
        check_eq(int'(timeout_val), 0, "R6", "timeout zero");
        refs(10*PRESC);
        step(1'b0, 1'b1, 8'hC0, 1'b0);
        refs(10*PRESC);
        settle();
        check_eq(int'(wdf), 0, "R6", "no flag when disabled");
        check_eq(int'(count), 0, "R6", "count stays zero");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule